// File: doc/BRIEF.md
# Serial LCD Byte Writer

This block sends one byte at a time to a graphic LCD controller over a four-wire link: chip select (active low), data/command select, serial clock and serial data. A user-side strobe starts a transfer. The strobe captures a byte and a flag that marks the byte as display data or as a controller command. While the byte goes out, the block reports busy. It then gives a single-cycle done pulse.

Each transfer runs in a fixed order:

1. Chip select falls.
2. The data/command line is held at the flag value for the whole byte.
3. Eight bits leave most significant first. For each bit, clock and data first drop low together. Data then takes the bit value, and the clock then rises. The display samples on that rising edge.
4. The clock is left high and chip select rises.

The `DIV` parameter sets how many system clocks each phase lasts. It therefore sets the serial bit rate, which is one bit per 3·`DIV` clocks.

Top module: `lcd_byte_writer`

## Requirements
- R1: While reset is held and right after it, `lcd_cs_n`=1, `lcd_sck`=1, `lcd_sda`=0, `lcd_dc`=0, `busy`=0 and `done`=0.
- R2: Chip select goes low in the cycle after an accepted start strobe. It stays low until exactly 8 rising edges of `lcd_sck` have occurred, then goes high.
- R3: The values of `lcd_sda` at the 8 rising clock edges of a frame are the bits of `wr_byte`, bit 7 first and bit 0 last.
- R4: `lcd_dc` equals the captured `wr_data` (1 = data byte, 0 = command byte). It does not change while `lcd_cs_n` is low, even if `wr_data` changes.
- R5: Each bit starts with `lcd_sck` and `lcd_sda` both low. `lcd_sda` then takes the bit value and holds it for at least `DIV` cycles before `lcd_sck` rises. `lcd_sda` does not change while `lcd_sck` is high inside a frame.
- R6: `lcd_sck` is high whenever `lcd_cs_n` is high, including the end of every transfer.
- R7: `busy` is high from the cycle after an accepted strobe until the frame ends. A strobe is accepted only when `busy` is low. A strobe while `busy` is high has no effect on the lines or on later frames.
- R8: `done` is high for exactly one cycle per frame, the cycle in which `busy` falls. Between two frames `lcd_cs_n` stays high for at least `DIV` cycles.
- R9: `done` is high in the cycle that follows the clock edge 26·`DIV` cycles after the edge that accepted the strobe. The cycle count is (3·8+2)·`DIV`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe; accepted when busy is low |
| wr_byte | input | 8 | Byte to send, captured with the strobe |
| wr_data | input | 1 | 1 = data byte, 0 = command byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at frame end |
| lcd_cs_n | output | 1 | Display chip select, active low |
| lcd_dc | output | 1 | Display data/command select |
| lcd_sck | output | 1 | Serial clock, parked high |
| lcd_sda | output | 1 | Serial data |

## Verification
The hardest cases are a strobe issued in the single cycle where `done` is high, and a strobe that lands in the middle of a frame. The first must start the next frame while still keeping chip select high for the minimum gap. The second must leave both the current frame and the next one untouched.

The driver waits at the falling clock edge until `busy` drops, so back-to-back sends land exactly on the done cycle. A separate poke task fires strobes with conflicting byte and flag values while a frame is in flight. The scoreboard then confirms that only the queued bytes appear on the wire, with their own data/command levels.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD,
    PH_CLR,
    PH_SET,
    PH_RISE,
    PH_TAIL
  } lcdw_phase_e;

  // width of a counter that must reach div-1
  function automatic int cnt_bits(input int div);
    return (div < 2) ? 1 : $clog2(div);
  endfunction

  // width of an index that must reach n-1
  function automatic int idx_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/lcdw_pace.sv
module lcdw_pace
  import lcdw_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic phase_end
);
  localparam int CW = cnt_bits(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign phase_end = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lcdw_shifter.sv
module lcdw_shifter
  import lcdw_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [BITS-1:0] din,
  input  logic            step,
  output logic            msb,
  output logic            last
);
  localparam int IW = idx_bits(BITS);
  localparam logic [IW-1:0] TOP = IW'(BITS - 1);

  logic [BITS-1:0] sreg;
  logic [IW-1:0]   idx;

  assign msb  = sreg[BITS-1];
  assign last = (idx == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      idx  <= '0;
    end else if (load) begin
      sreg <= din;
      idx  <= '0;
    end else if (step) begin
      sreg <= {sreg[BITS-2:0], 1'b0};
      idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_byte_writer.sv
module lcd_byte_writer
  import lcdw_pkg::*;
#(
  parameter int DIV  = 4,
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [BITS-1:0] wr_byte,
  input  logic            wr_data,
  output logic            busy,
  output logic            done,
  output logic            lcd_cs_n,
  output logic            lcd_dc,
  output logic            lcd_sck,
  output logic            lcd_sda
);
  lcdw_phase_e ph;
  logic        phase_end;
  logic        accept_w;
  logic        bit_step_w;
  logic        frame_end_w;
  logic        msb;
  logic        last_bit;
  logic        dc_q;
  logic        done_q;

  assign accept_w    = (ph == PH_IDLE) && start;
  assign bit_step_w  = (ph == PH_RISE) && phase_end && !last_bit;
  assign frame_end_w = (ph == PH_TAIL) && phase_end;

  lcdw_pace #(.DIV(DIV)) u_pace (
    .clk       (clk),
    .rst       (rst),
    .run       (ph != PH_IDLE),
    .phase_end (phase_end)
  );

  lcdw_shifter #(.BITS(BITS)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .load (accept_w),
    .din  (wr_byte),
    .step (bit_step_w),
    .msb  (msb),
    .last (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      dc_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= frame_end_w;
      unique case (ph)
        PH_IDLE: if (start) begin
          ph   <= PH_LEAD;
          dc_q <= wr_data;
        end
        PH_LEAD: if (phase_end) ph <= PH_CLR;
        PH_CLR:  if (phase_end) ph <= PH_SET;
        PH_SET:  if (phase_end) ph <= PH_RISE;
        PH_RISE: if (phase_end) ph <= last_bit ? PH_TAIL : PH_CLR;
        PH_TAIL: if (phase_end) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy     = (ph != PH_IDLE);
  assign done     = done_q;
  assign lcd_cs_n = (ph == PH_IDLE) || (ph == PH_TAIL);
  assign lcd_sck  = !((ph == PH_CLR) || (ph == PH_SET));
  assign lcd_sda  = ((ph == PH_SET) || (ph == PH_RISE)) && msb;
  assign lcd_dc   = dc_q;
endmodule

// File: rtl/lcdw_chk.sv
module lcdw_chk #(
  parameter int DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic cs_n,
  input logic sck,
  input logic sda,
  input logic dc,
  input logic frame_end
);
  logic [15:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= 16'hFFFF;
    end else if (!cs_n) begin
      gap_cnt <= '0;
    end else if (gap_cnt != 16'hFFFF) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R6
  sck_parked_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sck);

  // R4
  dc_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && $past(!cs_n)) |-> $stable(dc));

  // R5
  sda_low_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sck) |-> !sda);

  // R5
  sda_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
    (sck && !cs_n && $past(!cs_n)) |-> $stable(sda));

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && !cs_n));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (done && !busy));

  // R8
  gap_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (gap_cnt >= 16'(DIV)));
endmodule

bind lcd_byte_writer lcdw_chk #(.DIV(DIV)) u_lcdw_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .cs_n      (lcd_cs_n),
  .sck       (lcd_sck),
  .sda       (lcd_sda),
  .dc        (lcd_dc),
  .frame_end (frame_end_w)
);

// File: tb/test_lcd_byte_writer.sv
`timescale 1ns/1ps
module test_lcd_byte_writer;
  localparam int DIV = 3;
  localparam int FRAME = (3 * 8 + 2) * DIV;

  typedef struct {
    logic       dcv;
    logic [7:0] b;
    int         acc;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       wr_data = 1'b0;
  logic       busy, done, lcd_cs_n, lcd_dc, lcd_sck, lcd_sda;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int frames_seen = 0;
  int frames_sent = 0;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lcd_byte_writer #(.DIV(DIV)) i_lcd_byte_writer (
    .clk(clk), .rst(rst), .start(start), .wr_byte(wr_byte), .wr_data(wr_data),
    .busy(busy), .done(done), .lcd_cs_n(lcd_cs_n), .lcd_dc(lcd_dc),
    .lcd_sck(lcd_sck), .lcd_sda(lcd_sda)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // driver: waits for idle, strobes, records expectation
  task automatic send(input logic [7:0] b, input logic d);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    wr_byte = b; wr_data = d; start = 1'b1;
    it.dcv = d; it.b = b; it.acc = cyc + 1;
    q.push_back(it);
    frames_sent++;
    @(negedge clk);
    start = 1'b0;
  endtask

  // strobe while busy: must be ignored
  task automatic poke(input logic [7:0] b, input logic d);
    @(negedge clk);
    chk(busy == 1'b1, "R7 poke lands while busy", busy, 1);
    wr_byte = b; wr_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wr_data = ~d;
  endtask

  // monitor / scoreboard
  logic       p_sck = 1'b1, p_cs = 1'b1, p_sda = 1'b0, p_done = 1'b0;
  int         sda_age = 0;
  int         nbits = 0;
  logic [7:0] got = 8'h00;
  logic       dc_at_fall = 1'b0;
  bit         dc_moved = 1'b0;
  int         cs_fall_cyc = 0;
  int         cs_hi_cnt = 1000;
  item_t      cur;
  bit         have_cur = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      sda_age = (lcd_sda == p_sda) ? sda_age + 1 : 1;
      // R6 clock parked while deselected
      if (lcd_cs_n) chk(lcd_sck == 1'b1, "R6 sck high while cs_n high", lcd_sck, 1);
      if (!lcd_cs_n && p_cs) begin
        if (frames_seen > 0)
          chk(cs_hi_cnt >= DIV, "R8 cs_n high gap", cs_hi_cnt, DIV);
        cs_fall_cyc = cyc;
        nbits = 0; got = 8'h00; dc_at_fall = lcd_dc; dc_moved = 1'b0;
      end
      if (!lcd_cs_n && !p_cs && lcd_dc != dc_at_fall) dc_moved = 1'b1;
      if (!lcd_cs_n && p_sck && !lcd_sck)
        chk(lcd_sda == 1'b0, "R5 sda low when sck falls", lcd_sda, 0);
      if (!lcd_cs_n && !p_sck && lcd_sck) begin
        chk(sda_age > DIV, "R5 sda setup before rise", sda_age, DIV + 1);
        chk(busy == 1'b1, "R7 busy during frame", busy, 1);
        got = {got[6:0], lcd_sda};
        nbits++;
      end
      if (!lcd_cs_n && lcd_sck && !p_sck == 1'b0 && p_sck && lcd_sda != p_sda && !p_cs)
        chk(1'b0, "R5 sda moved while sck high", lcd_sda, p_sda);
      if (lcd_cs_n && !p_cs) begin
        frames_seen++;
        chk(nbits == 8, "R2 rising edges per frame", nbits, 8);
        chk(lcd_sck == 1'b1, "R6 sck high at frame end", lcd_sck, 1);
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected frame", got, 0);
          have_cur = 1'b0;
        end else begin
          cur = q.pop_front();
          have_cur = 1'b1;
          chk(got == cur.b, "R3 byte MSB first", got, cur.b);
          chk(dc_at_fall == cur.dcv, "R4 dc level", dc_at_fall, cur.dcv);
          chk(!dc_moved, "R4 dc steady in frame", dc_moved, 0);
          chk(cs_fall_cyc == cur.acc, "R2 cs_n falls after accept", cs_fall_cyc, cur.acc);
        end
      end
      if (done) begin
        chk(p_done == 1'b0, "R8 done single cycle", p_done, 0);
        chk(busy == 1'b0, "R8 busy low with done", busy, 0);
        if (have_cur)
          chk(cyc == cur.acc + FRAME, "R9 done latency", cyc, cur.acc + FRAME);
        have_cur = 1'b0;
      end
      cs_hi_cnt = lcd_cs_n ? cs_hi_cnt + 1 : 0;
      p_sck = lcd_sck; p_cs = lcd_cs_n; p_sda = lcd_sda; p_done = done;
    end
  end

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 state under reset
    chk({lcd_cs_n, lcd_sck, lcd_sda, lcd_dc, busy, done} == 6'b110000,
        "R1 reset outputs", {lcd_cs_n, lcd_sck, lcd_sda, lcd_dc, busy, done}, 6'b110000);
    rst = 1'b0;
    @(negedge clk);
    chk({lcd_cs_n, lcd_sck, lcd_sda, lcd_dc, busy, done} == 6'b110000,
        "R1 outputs after reset", {lcd_cs_n, lcd_sck, lcd_sda, lcd_dc, busy, done}, 6'b110000);
    repeat (3) @(negedge clk);

    send(8'hA5, 1'b1);
    send(8'h3C, 1'b0);   // back-to-back on the done cycle
    send(8'hFF, 1'b1);
    send(8'h00, 1'b0);
    send(8'h80, 1'b1);
    send(8'h01, 1'b0);

    // R7 strobes during a frame are ignored
    send(8'h5A, 1'b1);
    repeat (10) @(negedge clk);
    poke(8'hC3, 1'b0);
    repeat (20) @(negedge clk);
    poke(8'h0F, 1'b0);
    send(8'h96, 1'b0);

    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2 * FRAME) @(negedge clk);
    chk(busy == 1'b0, "R7 no frame from ignored strobe", busy, 0);
    chk(frames_seen == frames_sent, "R7 frame count", frames_seen, frames_sent);
    chk(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule